// File: doc/BRIEF.md
# Vector Length Setting Unit

This unit executes a set-vector-length operation in one clock edge. From an immediate field, two mode bits, a general register operand, a counter operand and the vector state it holds, it derives a new maximum vector length and a new vector length. Register and counter requests are saturated to the largest value that fits the length field. The result is then clamped so that it never exceeds the maximum. Either event raises an overflow flag for that operation.

The unit rewrites its state word with the two lengths and zeroes the element-step fields. When the destination register index is nonzero, it returns the new vector length for the register file. When the record bit is set, it produces a 4-bit condition field. The summary-overflow bit of that field is the stored summary overflow ORed with the overflow flag; the stored bit itself is never written. Decode, the register file and the fixed-point exception register live outside the unit and reach it through ports.

Top module: `vlen_set_unit`

## Requirements
- R1: After reset, `state_o` is all zero and `rt_we_o` and `cr_we_o` are low.
- R2: The immediate length is `(svi_i + 1) mod 128`. When `set_mvl_i` is 1, the new maximum takes that value; otherwise the maximum keeps its stored value.
- R3: When `set_vl_i` is 0, the length request is the stored vector length, still subject to the clamp of R7.
- R4: When `set_vl_i` is 1 and `ra_sel_i` is nonzero, a `ra_val_i` above 127 requests 127 and raises overflow; otherwise the request is `ra_val_i[6:0]`.
- R5: When `set_vl_i` is 1 and both `ra_sel_i` and `rt_sel_i` are zero, the request is the immediate length.
- R6: When `set_vl_i` is 1, `ra_sel_i` is zero and `rt_sel_i` is nonzero, the request comes from `ctr_i`, saturated to 127 with overflow when it is above 127.
- R7: A request above the new maximum is replaced by the maximum and raises overflow. A request equal to the maximum raises no overflow.
- R8: On an operation, `state_o` holds the maximum in bits [28:22] and the vector length in bits [21:15]. Bits [14:0], which hold the source step, destination step and first-element flag, are zero.
- R9: One cycle after an operation with nonzero `rt_sel_i`, `rt_we_o` pulses and `rt_data_o` is the new vector length zero-extended to 64 bits. With `rt_sel_i` zero, `rt_we_o` stays low.
- R10: One cycle after an operation with `record_i` set, `cr_we_o` pulses with `cr_o` = {LT, GT, EQ, SO} (bit 3 down to bit 0). LT is 0, GT is set when the length is nonzero, EQ is set when it is zero, and SO is `so_i` OR the overflow flag. Without `record_i`, `cr_we_o` stays low.
- R11: While `valid_i` is low, `state_o` does not change and both write strobes stay low, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| svi_i | input | 7 | Immediate length field minus one |
| set_mvl_i | input | 1 | Write the maximum from the immediate |
| set_vl_i | input | 1 | Write a new vector length request |
| ra_sel_i | input | 5 | Source register index |
| ra_val_i | input | 64 | Source register value |
| rt_sel_i | input | 5 | Destination register index |
| ctr_i | input | 64 | Counter register value |
| record_i | input | 1 | Produce a condition field |
| so_i | input | 1 | Stored summary-overflow bit |
| state_o | output | 29 | Vector state word |
| rt_we_o | output | 1 | Destination register write strobe |
| rt_data_o | output | 64 | Destination register write data |
| cr_we_o | output | 1 | Condition field write strobe |
| cr_o | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The assertions check properties that hold on every cycle. The stored length never exceeds the stored maximum. The state and both strobes do not move while no operation is presented. The returned register value always equals the stored length, zero-extended. A set summary-overflow input always shows in the recorded field. The bench's sweeps are needed for the rest: the exact source selected in each mode, where saturation and clamping begin, the wrap of the immediate, and the rule that an exact-limit request leaves SO clear. The bench computes each expected value arithmetically and compares it at the ports.

// File: rtl/vlen_pkg.sv
package vlen_pkg;
  typedef enum logic [1:0] {
    VL_SRC_KEEP,
    VL_SRC_REG,
    VL_SRC_IMM,
    VL_SRC_CTR
  } vl_src_e;

  localparam int CR_W  = 4;
  localparam int CR_LT = 3;
  localparam int CR_GT = 2;
  localparam int CR_EQ = 1;
  localparam int CR_SO = 0;
endpackage

// File: rtl/vlen_sat.sv
module vlen_sat #(
  parameter int IN_W  = 64,
  parameter int OUT_W = 7
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] val_o,
  output logic             sat_o
);
  localparam logic [IN_W-1:0] LIMIT = {{(IN_W-OUT_W){1'b0}}, {OUT_W{1'b1}}};

  assign sat_o = val_i > LIMIT;
  assign val_o = sat_o ? {OUT_W{1'b1}} : val_i[OUT_W-1:0];
endmodule

// File: rtl/vlen_select.sv
module vlen_select
  import vlen_pkg::*;
#(
  parameter int LEN_W = 7,
  parameter int XLEN  = 64
) (
  input  vl_src_e          src_i,
  input  logic [LEN_W-1:0] cur_vl_i,
  input  logic [LEN_W-1:0] new_mvl_i,
  input  logic [LEN_W-1:0] imm_i,
  input  logic [XLEN-1:0]  ra_val_i,
  input  logic [XLEN-1:0]  ctr_i,
  output logic [LEN_W-1:0] vl_o,
  output logic             ovf_o
);
  localparam int N_WIDE = 2;

  logic [N_WIDE-1:0][XLEN-1:0]  wide_in;
  logic [N_WIDE-1:0][LEN_W-1:0] wide_sat;
  logic [N_WIDE-1:0]            wide_ovf;
  logic [LEN_W-1:0]             req;
  logic                         req_ovf;

  assign wide_in[0] = ra_val_i;
  assign wide_in[1] = ctr_i;

  for (genvar g = 0; g < N_WIDE; g++) begin : g_sat
    vlen_sat #(.IN_W(XLEN), .OUT_W(LEN_W)) i_sat (
      .val_i (wide_in[g]),
      .val_o (wide_sat[g]),
      .sat_o (wide_ovf[g])
    );
  end

  always_comb begin
    unique case (src_i)
      VL_SRC_REG: begin req = wide_sat[0]; req_ovf = wide_ovf[0]; end
      VL_SRC_CTR: begin req = wide_sat[1]; req_ovf = wide_ovf[1]; end
      VL_SRC_IMM: begin req = imm_i;       req_ovf = 1'b0;        end
      default:    begin req = cur_vl_i;    req_ovf = 1'b0;        end
    endcase
  end

  // clamp to the new maximum; equality is not an overflow
  always_comb begin
    if (req > new_mvl_i) begin
      vl_o  = new_mvl_i;
      ovf_o = 1'b1;
    end else begin
      vl_o  = req;
      ovf_o = req_ovf;
    end
  end
endmodule

// File: rtl/vlen_cond.sv
module vlen_cond
  import vlen_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic [LEN_W-1:0] vl_i,
  input  logic             so_i,
  input  logic             ovf_i,
  output logic [CR_W-1:0]  cr_o
);
  // value is zero-extended, so it is never negative
  always_comb begin
    cr_o        = '0;
    cr_o[CR_LT] = 1'b0;
    cr_o[CR_GT] = |vl_i;
    cr_o[CR_EQ] = ~|vl_i;
    cr_o[CR_SO] = so_i | ovf_i;
  end
endmodule

// File: rtl/vlen_set_unit.sv
module vlen_set_unit
  import vlen_pkg::*;
#(
  parameter int LEN_W  = 7,
  parameter int STEP_W = 7,
  parameter int XLEN   = 64,
  parameter int IDX_W  = 5,
  parameter int STATE_W = 2*LEN_W + 2*STEP_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [LEN_W-1:0]   svi_i,
  input  logic               set_mvl_i,
  input  logic               set_vl_i,
  input  logic [IDX_W-1:0]   ra_sel_i,
  input  logic [XLEN-1:0]    ra_val_i,
  input  logic [IDX_W-1:0]   rt_sel_i,
  input  logic [XLEN-1:0]    ctr_i,
  input  logic               record_i,
  input  logic               so_i,
  output logic [STATE_W-1:0] state_o,
  output logic               rt_we_o,
  output logic [XLEN-1:0]    rt_data_o,
  output logic               cr_we_o,
  output logic [CR_W-1:0]    cr_o
);
  localparam int TAIL_W = STATE_W - 2*LEN_W;

  logic [LEN_W-1:0] mvl_q, vl_q;
  logic [LEN_W-1:0] imm, new_mvl, new_vl;
  logic             ovf;
  vl_src_e          src;
  logic [CR_W-1:0]  cr_d;

  assign imm     = svi_i + LEN_W'(1);
  assign new_mvl = set_mvl_i ? imm : mvl_q;

  always_comb begin
    if (!set_vl_i)             src = VL_SRC_KEEP;
    else if (ra_sel_i != '0)   src = VL_SRC_REG;
    else if (rt_sel_i == '0)   src = VL_SRC_IMM;
    else                       src = VL_SRC_CTR;
  end

  vlen_select #(.LEN_W(LEN_W), .XLEN(XLEN)) i_select (
    .src_i     (src),
    .cur_vl_i  (vl_q),
    .new_mvl_i (new_mvl),
    .imm_i     (imm),
    .ra_val_i  (ra_val_i),
    .ctr_i     (ctr_i),
    .vl_o      (new_vl),
    .ovf_o     (ovf)
  );

  vlen_cond #(.LEN_W(LEN_W)) i_cond (
    .vl_i  (new_vl),
    .so_i  (so_i),
    .ovf_i (ovf),
    .cr_o  (cr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mvl_q     <= '0;
      vl_q      <= '0;
      rt_we_o   <= 1'b0;
      rt_data_o <= '0;
      cr_we_o   <= 1'b0;
      cr_o      <= '0;
    end else begin
      rt_we_o <= valid_i && (rt_sel_i != '0);
      cr_we_o <= valid_i && record_i;
      if (valid_i) begin
        mvl_q     <= new_mvl;
        vl_q      <= new_vl;
        rt_data_o <= {{(XLEN-LEN_W){1'b0}}, new_vl};
        cr_o      <= cr_d;
      end
    end
  end

  // step counters and first-element flag always end at zero
  assign state_o = {mvl_q, vl_q, {TAIL_W{1'b0}}};

  p_vl_le_mvl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o[STATE_W-LEN_W-1 -: LEN_W] <= state_o[STATE_W-1 -: LEN_W]);

  p_hold_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(state_o));

  p_no_strobe_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!rt_we_o && !cr_we_o));

  p_rt_matches_vl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rt_we_o |-> (rt_data_o == {{(XLEN-LEN_W){1'b0}}, state_o[STATE_W-LEN_W-1 -: LEN_W]}));

  p_so_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && record_i && so_i) |=> (cr_we_o && cr_o[CR_SO]));
endmodule

// File: tb/test_vlen_set_unit.sv
module test_vlen_set_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [6:0]  svi = '0;
  logic        set_mvl = 1'b0, set_vl = 1'b0;
  logic [4:0]  ra_sel = '0, rt_sel = '0;
  logic [63:0] ra_val = '0, ctr = '0;
  logic        record = 1'b0, so = 1'b0;
  logic [28:0] state;
  logic        rt_we, cr_we;
  logic [63:0] rt_data;
  logic [3:0]  cr;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int mvl_m = 0, vl_m = 0;

  always #5 clk = ~clk;

  vlen_set_unit i_vlen_set_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .svi_i(svi),
    .set_mvl_i(set_mvl), .set_vl_i(set_vl), .ra_sel_i(ra_sel),
    .ra_val_i(ra_val), .rt_sel_i(rt_sel), .ctr_i(ctr),
    .record_i(record), .so_i(so), .state_o(state), .rt_we_o(rt_we),
    .rt_data_o(rt_data), .cr_we_o(cr_we), .cr_o(cr)
  );

  task automatic check(string tag, string what, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic op(string tag, bit smvl, bit svl, int imm_f, int ras, longint unsigned rav,
                    int rts, longint unsigned ctv, bit rec, bit so_in);
    int imm, nm, v;
    bit o;
    imm = (imm_f + 1) % 128;
    nm  = smvl ? imm : mvl_m;
    o   = 0;
    if (!svl) v = vl_m;
    else if (ras != 0) begin
      if (rav > 127) begin v = 127; o = 1; end else v = int'(rav % 128);
    end else if (rts == 0) v = imm;
    else begin
      if (ctv > 127) begin v = 127; o = 1; end else v = int'(ctv % 128);
    end
    if (v > nm) begin v = nm; o = 1; end
    mvl_m = nm;
    vl_m  = v;
    @(negedge clk);
    valid = 1; set_mvl = smvl; set_vl = svl; svi = 7'(imm_f);
    ra_sel = 5'(ras); ra_val = rav; rt_sel = 5'(rts); ctr = ctv;
    record = rec; so = so_in;
    @(negedge clk);
    valid = 0;
    check("R2", "mvl", state[28:22], nm);
    check(tag, "vl", state[21:15], v);
    check("R8", "steps", state[14:0], 0);
    check("R9", "rt_we", rt_we, rts != 0);
    if (rts != 0) check("R9", "rt_data", rt_data, v);
    check("R10", "cr_we", cr_we, rec);
    if (rec) check(tag, "cr", cr, {1'b0, v != 0, v == 0, so_in | o});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "state", state, 0);
    check("R1", "rt_we", rt_we, 0);
    check("R1", "cr_we", cr_we, 0);
    rst_n = 1;

    // R2/R5: immediate sweep incl. wrap at 127
    for (int s = 0; s < 128; s++) op("R5", 1, 1, s, 0, 0, 0, 0, 1, 0);

    // R4: register source, both around the limit and around the maximum
    for (int m = 0; m < 2; m++) begin
      op("R2", 1, 0, (m == 0) ? 4 : 126, 0, 0, 0, 0, 0, 0);
      for (int r = 0; r < 140; r++) op("R4", 0, 1, 0, 4, longint'(r), 5, 0, 1, 0);
      op("R4", 0, 1, 0, 4, 1000, 5, 0, 1, 0);
      op("R4", 0, 1, 0, 31, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 1, 0);
      op("R4", 0, 1, 0, 4, 64'h100, 5, 0, 1, 0);
    end
    // exact-limit request: no overflow (R7)
    op("R7", 1, 1, 126, 4, 127, 5, 0, 1, 0);
    op("R7", 1, 1, 126, 4, 1000, 5, 0, 1, 0);
    op("R7", 1, 1, 4, 4, 1000, 5, 0, 1, 0);

    // R6: counter source
    for (int m = 0; m < 2; m++) begin
      op("R2", 1, 0, (m == 0) ? 9 : 126, 0, 0, 0, 0, 0, 0);
      for (int c = 0; c < 140; c++) op("R6", 0, 1, 0, 0, 0, 3, longint'(c), 1, 0);
      op("R6", 0, 1, 0, 0, 0, 3, 64'h8000_0000_0000_0000, 1, 0);
    end

    // R3: keep mode, then shrink maximum below the stored length
    op("R3", 1, 1, 126, 0, 0, 0, 0, 0, 0);
    for (int s = 126; s >= 0; s -= 7) op("R3", 1, 0, s, 0, 0, 2, 0, 1, 0);
    op("R3", 0, 0, 0, 0, 0, 2, 0, 1, 0);

    // R10: stored summary overflow passes through; R9 no write to r0
    for (int s = 0; s < 8; s++) op("R10", 1, 1, s * 16, 0, 0, 0, 0, 1, 1);
    op("R10", 1, 1, 127, 0, 0, 0, 0, 1, 0);

    // R11: no valid, busy inputs
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      valid = 0; set_mvl = 1; set_vl = 1; svi = 7'(k * 5);
      ra_sel = 5'(k); ra_val = longint'(k * 77); rt_sel = 5'(k + 1); record = 1;
      @(negedge clk);
      check("R11", "mvl", state[28:22], mvl_m);
      check("R11", "vl", state[21:15], vl_m);
      check("R11", "rt_we", rt_we, 0);
      check("R11", "cr_we", cr_we, 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule